// File: doc/BRIEF.md
# TDM Audio Lane Serializer

This block is the transmit half of one serial audio data lane. It turns parallel sample words into a serial bit stream, most significant bit first, one bit per bit-clock tick. The bit-clock tick (`bclk_en`) and the frame-start strobe come from a clock generator outside the block. Words arrive over a valid/ready input. The block also drives the word-select or frame-sync line that belongs with the chosen framing.

Four framings are supported: the classic two-channel standard, where data lags the word-select edge by one bit; left-justified; right-justified; and a PCM mode with a one-tick sync pulse. Samples may be 16, 24 or 32 bits wide, in 16- or 32-bit channels. In TDM mode a frame holds an even number of slots, up to 16, and a mask chooses which slots carry data. If an enabled slot starts while no word is offered, the block flags an underflow and sends zeros in that slot.

All configuration inputs must stay constant while the block is out of reset.

Top module: `tdm_lane_serializer`

## Requirements
- R1: While `rst` is high, and afterwards until the first tick that has `frame_start` high, `sd_out`, `ws_out`, `underflow` and `s_ready` are 0, and ticks without `frame_start` have no effect.
- R2: Each tick where `bclk_en` is high sends one bit. The frame length is slot count times channel width, counted in ticks. A tick with `frame_start` high is frame position 0. Without `frame_start`, the position wraps to 0 after the last position. Outputs change only on clock edges where `bclk_en` is high.
- R3: The channel width is 32 bits whenever `data_size` is not 00. When `data_size` is 00, `wide_chan` selects 16 bits (0) or 32 bits (1).
- R4: `data_size` codes are 00 for 16 bits, 01 for 24 bits and 10 for 32 bits. Bits of `s_data` above the data width are ignored. Channel bits that carry no data bit are sent as 0.
- R5: `fmt_sel`=00, two-channel standard. Each slot's MSB goes out one tick after the slot boundary, and the last bit of the frame spills into position 0 of the next frame. `ws_out` is 0 for the first half of the frame and 1 for the second half.
- R6: `fmt_sel`=01, left-justified. The MSB goes out on the first tick of the slot. `ws_out` is 1 for the first half of the frame and 0 for the second half.
- R7: `fmt_sel`=10, right-justified. The LSB occupies the last tick of the channel and leading bits are 0. `ws_out` behaves as in R6.
- R8: `fmt_sel`=11, PCM. `ws_out` is 1 only at frame position 0. Data lags by one tick as in R5, so the MSB follows the sync pulse directly.
- R9: With `tdm_on`=1 the frame has `ch_count` slots (even, 2 to 16). With `tdm_on`=0 it has 2 slots, whatever `ch_count` holds.
- R10: Bit i of `slot_mask` enables slot i. A disabled slot takes no word, sends zeros and raises no underflow.
- R11: `s_ready` is high only during the tick cycle in which an enabled slot's first data bit is sent (one tick after the boundary in the lagged modes). A word is taken when `s_valid` and `s_ready` are both high.
- R12: If `s_valid` is low when `s_ready` is high, `underflow` pulses for one cycle on the same edge that sends that bit, and the whole slot is sent as zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | Bit-clock tick, one bit per high cycle |
| frame_start | input | 1 | Marks the tick that is frame position 0 |
| fmt_sel | input | 2 | Framing code (R5 to R8) |
| data_size | input | 2 | Sample width code (R4) |
| wide_chan | input | 1 | 32-bit channel select when samples are 16 bits |
| tdm_on | input | 1 | Enables the multi-slot frame |
| ch_count | input | 5 | Slot count in TDM mode |
| slot_mask | input | 16 | Per-slot enable |
| s_valid | input | 1 | Sample word offered |
| s_data | input | 32 | Sample word, right-aligned |
| s_ready | output | 1 | Sample word taken this cycle when valid |
| sd_out | output | 1 | Serial data |
| ws_out | output | 1 | Word select / frame sync |
| underflow | output | 1 | One-cycle pulse: slot started with no word |

## Verification
Slot loading and bit emission happen on the same tick. The first bit of a new slot comes from the word being taken in that very cycle, and in the lagged modes position 0 still sends the previous frame's last word. The bench covers both cases with full-width words, where the frame-spill LSB is non-zero, and judges them bit by bit against a frame model. Underflow and the zero fill it causes also fall on one edge. The bench provokes this by withholding `s_valid` for whole frames and compares the pulse position and the zero stream at every tick.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned MAX_SLOTS = 16;
    localparam int unsigned MAX_CW    = 32;
    localparam int unsigned HI_SH     = $clog2(MAX_CW);
    localparam int unsigned LO_SH     = HI_SH - 1;
    localparam int unsigned SLOT_W    = $clog2(MAX_SLOTS);
    localparam int unsigned BIT_W     = $clog2(MAX_CW);
    localparam int unsigned CNT_W     = $clog2(MAX_SLOTS) + 1;
    localparam int unsigned LEN_W     = $clog2(MAX_SLOTS * MAX_CW) + 1;
    localparam int unsigned DW_W      = $clog2(WORD_W) + 1;

    typedef enum logic [1:0] {
        FMT_CLASSIC = 2'b00,
        FMT_LEFT    = 2'b01,
        FMT_RIGHT   = 2'b10,
        FMT_PCM     = 2'b11
    } fmt_e;

    typedef struct packed {
        fmt_e             fmt;
        logic             cw32;
        logic [DW_W-1:0]  dw;
        logic [CNT_W-1:0] nslots;
    } frame_cfg_t;

    function automatic logic [DW_W-1:0] data_bits(input logic [1:0] code);
        case (code)
            2'b00:   return DW_W'(16);
            2'b01:   return DW_W'(24);
            default: return DW_W'(32);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] slot_total(input logic tdm,
                                                    input logic [4:0] n);
        if (!tdm || n < 5'd2)
            return CNT_W'(2);
        if (CNT_W'(n) > CNT_W'(MAX_SLOTS))
            return CNT_W'(MAX_SLOTS);
        return CNT_W'(n);
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(input frame_cfg_t c);
        logic [LEN_W-1:0] n;
        n = LEN_W'(c.nslots);
        return c.cw32 ? (n << HI_SH) : (n << LO_SH);
    endfunction

    function automatic logic lagged(input fmt_e f);
        return (f == FMT_CLASSIC) || (f == FMT_PCM);
    endfunction

endpackage

// File: rtl/tdm_ser_timer.sv
module tdm_ser_timer
    import tdm_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              frame_start,
    input  frame_cfg_t        cfg,
    output logic              active,
    output logic [SLOT_W-1:0] slot,
    output logic [BIT_W-1:0]  bitn,
    output logic              ws_next
);

    logic [LEN_W-1:0] pos_q;
    logic [LEN_W-1:0] pos_now;
    logic [LEN_W-1:0] flen;
    logic [LEN_W-1:0] half;
    logic [LEN_W-1:0] eff;
    logic             synced_q;

    always_comb begin
        flen = frame_len(cfg);
        half = flen >> 1;
        if (frame_start)
            pos_now = '0;
        else if (pos_q >= flen - LEN_W'(1))
            pos_now = '0;
        else
            pos_now = pos_q + LEN_W'(1);

        active = tick & (synced_q | frame_start);

        if (lagged(cfg.fmt))
            eff = (pos_now == '0) ? flen - LEN_W'(1) : pos_now - LEN_W'(1);
        else
            eff = pos_now;

        slot = cfg.cw32 ? SLOT_W'(eff >> HI_SH) : SLOT_W'(eff >> LO_SH);
        bitn = cfg.cw32 ? eff[BIT_W-1:0] : {1'b0, eff[BIT_W-2:0]};

        case (cfg.fmt)
            FMT_CLASSIC: ws_next = (pos_now >= half);
            FMT_PCM:     ws_next = (pos_now == '0);
            default:     ws_next = (pos_now < half);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            synced_q <= 1'b0;
        end else if (active) begin
            pos_q    <= pos_now;
            synced_q <= 1'b1;
        end
    end

    // R2: the running position never leaves the frame
    a_r2_pos_in_frame: assert property (@(posedge clk) disable iff (rst)
        synced_q |-> (pos_q < flen));

    // R2: a frame-start tick always lands on position 0
    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        (tick && frame_start) |=> (pos_q == '0));

    // R1: no synchronisation before a frame start is seen
    a_r1_wait_sync: assert property (@(posedge clk) disable iff (rst)
        (!synced_q && !(tick && frame_start)) |=> !synced_q);

endmodule

// File: rtl/tdm_ser_loader.sv
module tdm_ser_loader
    import tdm_ser_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [BIT_W-1:0]     bitn,
    input  logic [MAX_SLOTS-1:0] slot_mask,
    input  logic [CNT_W-1:0]     nslots,
    input  logic [DW_W-1:0]      dw,
    input  logic                 s_valid,
    input  logic [WORD_W-1:0]    s_data,
    output logic                 s_ready,
    output logic [WORD_W-1:0]    word_now,
    output logic                 uf_now
);

    logic [WORD_W-1:0] cur_q;
    logic [WORD_W-1:0] dmask;
    logic              at_start;
    logic              slot_en;

    always_comb begin
        dmask    = {WORD_W{1'b1}} >> (7'(WORD_W) - {1'b0, dw});
        at_start = active && (bitn == '0);
        slot_en  = (CNT_W'(slot) < nslots) && slot_mask[slot];
        s_ready  = at_start && slot_en;
        uf_now   = s_ready && !s_valid;
        if (at_start)
            word_now = (s_ready && s_valid) ? (s_data & dmask) : '0;
        else
            word_now = cur_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else if (active)
            cur_q <= word_now;
    end

    // R12: a starved slot holds an all-zero word
    a_r12_zero_fill: assert property (@(posedge clk) disable iff (rst)
        uf_now |=> (cur_q == '0));

    // R10: a disabled slot holds an all-zero word
    a_r10_masked_zero: assert property (@(posedge clk) disable iff (rst)
        (at_start && !slot_en) |=> (cur_q == '0));

endmodule

// File: rtl/tdm_ser_bitsel.sv
module tdm_ser_bitsel
    import tdm_ser_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [BIT_W-1:0]  bitn,
    input  logic              cw32,
    input  logic [DW_W-1:0]   dw,
    input  logic              right,
    output logic              bit_o
);

    logic [DW_W-1:0] cw;
    logic [DW_W-1:0] b6;
    logic [DW_W-1:0] idx;

    always_comb begin
        cw    = cw32 ? DW_W'(MAX_CW) : DW_W'(MAX_CW / 2);
        b6    = {1'b0, bitn};
        idx   = '0;
        bit_o = 1'b0;
        if (right) begin
            idx   = cw - DW_W'(1) - b6;
            bit_o = word[idx[BIT_W-1:0]];
        end else if (b6 < dw) begin
            idx   = dw - DW_W'(1) - b6;
            bit_o = word[idx[BIT_W-1:0]];
        end
    end

endmodule

// File: rtl/tdm_lane_serializer.sv
module tdm_lane_serializer
    import tdm_ser_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bclk_en,
    input  logic        frame_start,
    input  logic [1:0]  fmt_sel,
    input  logic [1:0]  data_size,
    input  logic        wide_chan,
    input  logic        tdm_on,
    input  logic [4:0]  ch_count,
    input  logic [15:0] slot_mask,
    input  logic        s_valid,
    input  logic [31:0] s_data,
    output logic        s_ready,
    output logic        sd_out,
    output logic        ws_out,
    output logic        underflow
);

    frame_cfg_t        cfg;
    logic              active;
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bitn;
    logic              ws_next;
    logic [WORD_W-1:0] word_now;
    logic              uf_now;
    logic              bit_next;

    always_comb begin
        cfg.fmt    = fmt_e'(fmt_sel);
        cfg.cw32   = (data_size != 2'b00) || wide_chan;
        cfg.dw     = data_bits(data_size);
        cfg.nslots = slot_total(tdm_on, ch_count);
    end

    tdm_ser_timer u_timer (
        .clk         (clk),
        .rst         (rst),
        .tick        (bclk_en),
        .frame_start (frame_start),
        .cfg         (cfg),
        .active      (active),
        .slot        (slot),
        .bitn        (bitn),
        .ws_next     (ws_next)
    );

    tdm_ser_loader u_loader (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .slot      (slot),
        .bitn      (bitn),
        .slot_mask (MAX_SLOTS'(slot_mask)),
        .nslots    (cfg.nslots),
        .dw        (cfg.dw),
        .s_valid   (s_valid),
        .s_data    (WORD_W'(s_data)),
        .s_ready   (s_ready),
        .word_now  (word_now),
        .uf_now    (uf_now)
    );

    tdm_ser_bitsel u_bitsel (
        .word  (word_now),
        .bitn  (bitn),
        .cw32  (cfg.cw32),
        .dw    (cfg.dw),
        .right (cfg.fmt == FMT_RIGHT),
        .bit_o (bit_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_out    <= 1'b0;
            ws_out    <= 1'b0;
            underflow <= 1'b0;
        end else begin
            underflow <= active && uf_now;
            if (active) begin
                sd_out <= bit_next;
                ws_out <= ws_next;
            end
        end
    end

    // R2: line outputs move only on tick edges
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !bclk_en |=> ($stable(sd_out) && $stable(ws_out)));

    // R12: underflow is a single-cycle pulse
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
        underflow |=> !underflow);

    // R11: one request per slot start, never two cycles running
    a_r11_single_ready: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> !s_ready);

    // R1: no request without a tick
    a_r1_ready_needs_tick: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> bclk_en);

endmodule

// File: tb/tdm_lane_serializer_test.sv
module tdm_lane_serializer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk_en = 1'b0;
    logic        frame_start = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [1:0]  data_size = 2'b00;
    logic        wide_chan = 1'b0;
    logic        tdm_on = 1'b0;
    logic [4:0]  ch_count = 5'd2;
    logic [15:0] slot_mask = 16'h0003;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_ready;
    logic        sd_out;
    logic        ws_out;
    logic        underflow;

    int n_checks = 0;
    int n_fail   = 0;
    int hk       = 0;
    bit finished = 0;

    typedef struct {
        logic  sd;
        logic  ws;
        logic  uf;
        string tag;
    } exp_t;

    exp_t sb[$];
    logic tick_q = 1'b0;

    always #10 clk = ~clk;

    tdm_lane_serializer uut (
        .clk(clk), .rst(rst), .bclk_en(bclk_en), .frame_start(frame_start),
        .fmt_sel(fmt_sel), .data_size(data_size), .wide_chan(wide_chan),
        .tdm_on(tdm_on), .ch_count(ch_count), .slot_mask(slot_mask),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .sd_out(sd_out), .ws_out(ws_out), .underflow(underflow)
    );

    function automatic logic [31:0] src(input int k);
        return (32'h9E3779B9 * (k + 1)) ^ (32'(k) << 11);
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard one entry per tick edge
    always @(posedge clk) tick_q <= bclk_en;
    always @(negedge clk) begin
        if (tick_q && !rst && !finished) begin
            if (sb.size() == 0) begin
                check("R2", 32'd1, 32'd0, "unexpected tick output");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {29'd0, sd_out, ws_out, underflow},
                      {29'd0, e.sd, e.ws, e.uf}, "sd/ws/uf");
            end
        end
    end

    task automatic do_tick(input logic fs, input logic feed, input exp_t e,
                           input logic exp_rdy);
        logic rdy;
        @(negedge clk);
        bclk_en     = 1'b1;
        frame_start = fs;
        s_valid     = feed;
        s_data      = src(hk);
        sb.push_back(e);
        #1;
        rdy = s_ready;
        check("R11", {31'd0, rdy}, {31'd0, exp_rdy}, "s_ready");
        @(posedge clk);
        if (rdy && feed) hk++;
        @(negedge clk);
        bclk_en     = 1'b0;
        frame_start = 1'b0;
        @(posedge clk);
    endtask

    task automatic run_cfg(input string tag, input logic [1:0] fmt,
                           input logic [1:0] dsz, input logic wide,
                           input logic tdm, input logic [4:0] nch,
                           input logic [15:0] mask, input logic feed,
                           input int frames);
        int dw, cw, ns, flen, k, taken;
        bit off;
        logic [31:0] fw[16];
        logic [31:0] pw[16];
        exp_t e;
        @(negedge clk);
        rst = 1'b1;
        fmt_sel = fmt; data_size = dsz; wide_chan = wide; tdm_on = tdm;
        ch_count = nch; slot_mask = mask; s_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        hk = 0;
        #1;
        check("R1", {28'd0, sd_out, ws_out, underflow, s_ready}, 32'd0, "reset state");
        dw   = (dsz == 2'b00) ? 16 : (dsz == 2'b01) ? 24 : 32;
        cw   = (dsz == 2'b00 && !wide) ? 16 : 32;
        ns   = tdm ? int'(nch) : 2;
        flen = ns * cw;
        off  = (fmt == 2'b00) || (fmt == 2'b11);
        for (int s = 0; s < 16; s++) pw[s] = '0;
        // R1: ticks before the first frame start do nothing
        e.sd = 1'b0; e.ws = 1'b0; e.uf = 1'b0; e.tag = "R1";
        do_tick(1'b0, feed, e, 1'b0);
        do_tick(1'b0, feed, e, 1'b0);
        k = 0;
        for (int f = 0; f < frames; f++) begin
            for (int s = 0; s < 16; s++) begin
                if (s < ns && mask[s] && feed) begin
                    fw[s] = src(k) & (32'hFFFF_FFFF >> (32 - dw));
                    k++;
                end else begin
                    fw[s] = '0;
                end
            end
            for (int p = 0; p < flen; p++) begin
                int ef, s, b, idx;
                logic [31:0] w;
                logic rdy;
                ef = off ? ((p == 0) ? flen - 1 : p - 1) : p;
                s  = ef / cw;
                b  = ef % cw;
                w  = (off && p == 0) ? pw[s] : fw[s];
                if (fmt == 2'b10) begin
                    idx  = cw - 1 - b;
                    e.sd = w[idx];
                end else if (b < dw) begin
                    idx  = dw - 1 - b;
                    e.sd = w[idx];
                end else begin
                    e.sd = 1'b0;
                end
                case (fmt)
                    2'b00:   e.ws = (p >= flen / 2);
                    2'b11:   e.ws = (p == 0);
                    default: e.ws = (p < flen / 2);
                endcase
                rdy   = (b == 0) && mask[s];
                e.uf  = rdy && !feed;
                e.tag = tag;
                do_tick(p == 0, feed, e, rdy);
            end
            for (int s = 0; s < 16; s++) pw[s] = fw[s];
        end
        taken = 0;
        if (feed)
            for (int s = 0; s < ns; s++) if (mask[s]) taken += frames;
        check("R10", 32'(hk), 32'(taken), "words consumed");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        run_cfg("R5",  2'b00, 2'b00, 1'b0, 1'b0, 5'd2,  16'h0003, 1'b1, 3);
        run_cfg("R3",  2'b00, 2'b01, 1'b0, 1'b0, 5'd2,  16'h0003, 1'b1, 3);
        run_cfg("R6",  2'b01, 2'b00, 1'b1, 1'b0, 5'd2,  16'h0003, 1'b1, 3);
        run_cfg("R4",  2'b01, 2'b01, 1'b0, 1'b0, 5'd2,  16'h0003, 1'b1, 3);
        run_cfg("R7",  2'b10, 2'b01, 1'b0, 1'b0, 5'd2,  16'h0003, 1'b1, 3);
        run_cfg("R7",  2'b10, 2'b00, 1'b1, 1'b0, 5'd2,  16'h0003, 1'b1, 2);
        run_cfg("R8",  2'b11, 2'b00, 1'b0, 1'b1, 5'd8,  16'h00B5, 1'b1, 3);
        run_cfg("R2",  2'b01, 2'b10, 1'b1, 1'b1, 5'd16, 16'hFFFF, 1'b1, 2);
        run_cfg("R9",  2'b01, 2'b10, 1'b0, 1'b0, 5'd8,  16'hFFFF, 1'b1, 3);
        run_cfg("R10", 2'b00, 2'b10, 1'b0, 1'b1, 5'd4,  16'h0006, 1'b1, 3);
        run_cfg("R12", 2'b00, 2'b00, 1'b0, 1'b0, 5'd2,  16'h0001, 1'b0, 3);
        run_cfg("R12", 2'b11, 2'b01, 1'b0, 1'b1, 5'd4,  16'h000F, 1'b0, 2);
        repeat (4) @(posedge clk);
        check("R2", 32'(sb.size()), 32'd0, "scoreboard drained");
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule